// File: doc/BRIEF.md
# Two-Stage Latched Code Register for a Multiplying Converter

This block is the digital front end of an 8-bit multiplying converter. A parallel data bus feeds a first holding stage (the staging register). Its content moves into a second stage (the code register), and that stage drives the code to the analog ladder. Each stage has its own compound enable. The staging register opens when chip select is low, the latch-enable is high and the first write strobe is low. The code register opens when the transfer strobe and the second write strobe are both low.

All strobes and data are sampled on the rising clock edge. A stage loads on every edge where its enable holds, so holding an enable active makes the stage follow its input. This gives three ways to use the block. Double-buffered operation uses two separate writes. Single-buffered operation keeps one stage always open. Flow-through operation keeps both stages open. Several instances can share one transfer strobe so that their outputs change on the same edge.

Each control pin has an "undriven" flag that forces the pin to logic 1. Next to the code, the block reports the complementary span: the number of LSBs between the code and the reference.

Top module: `dbuf_dac_front`

## Requirements
- R1: The staging register loads `din` on a rising edge only when `cs_n`=0, `ile`=1 and `wr1_n`=0 all hold together.
- R2: In every other combination of those three pins, the staging register keeps its value, whatever `din` does.
- R3: The code register loads on a rising edge only when `xfer_n`=0 and `wr2_n`=0; otherwise it keeps its value.
- R4: When both stages are enabled on the same edge, `din` reaches `code_q` on that edge, with one cycle of latency (flow-through).
- R5: Enables are level-sensitive. While an enable stays active, the stage reloads on every edge and follows each new input value.
- R6: `din[0]` is the LSB and maps to `code_q[0]`. `span_q` equals 2^W minus `code_q`. A code of all ones (full scale, reference minus one LSB) gives `span_q`=1, and all zeros gives 2^W.
- R7: `ctl_float` forces a control pin to 1 when its bit is set. The bit map is: 0 `cs_n`, 1 `ile`, 2 `wr1_n`, 3 `wr2_n`, 4 `xfer_n`.
- R8: A synchronous active-high `rst` clears both registers to 0 and sets `span_q` to 2^W.
- R9: Instances that share `xfer_n`/`wr2_n` all update on the same edge. Only instances whose staging register was written beforehand show a new code.
- R10: Single-buffered use, with the code register held open, makes `code_q` follow each staging-register write one edge later and hold between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | W | Parallel data bus, bit 0 LSB |
| cs_n | input | 1 | Chip select, active low |
| ile | input | 1 | Staging latch enable, active high |
| wr1_n | input | 1 | Staging write strobe, active low |
| wr2_n | input | 1 | Transfer write strobe, active low |
| xfer_n | input | 1 | Transfer select, active low |
| ctl_float | input | 5 | Per-pin undriven flags, force pin to 1 |
| hold_q | output | W | Staging register content |
| code_q | output | W | Code register, drives the ladder |
| span_q | output | W+1 | 2^W minus code_q |

## Verification
The hardest case to reach from the ports is a shared transfer that reaches several converters holding different histories. Three instances are driven from one bus and one transfer strobe, with a separate chip select for each. Two of them are written and one is left alone. Then a single transfer edge is applied and all three codes are compared on the same cycle.

The bench also sweeps all eight staging-enable combinations and all four transfer combinations. It sweeps every code in flow-through to cover the span arithmetic at both ends of the range.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  localparam int CTL_N     = 5;
  localparam int CTL_CS    = 0;
  localparam int CTL_ILE   = 1;
  localparam int CTL_WR1   = 2;
  localparam int CTL_WR2   = 3;
  localparam int CTL_XFER  = 4;
endpackage

// File: rtl/dbf_ctl_resolve.sv
module dbf_ctl_resolve
  import dbf_pkg::*;
(
  input  logic [CTL_N-1:0] raw,
  input  logic [CTL_N-1:0] flt,
  output logic             load_in,
  output logic             load_dac
);
  logic [CTL_N-1:0] eff;

  // an undriven pin reads as logic 1
  for (genvar i = 0; i < CTL_N; i++) begin : g_pin
    assign eff[i] = raw[i] | flt[i];
  end

  always_comb begin
    load_in  = !eff[CTL_CS] && eff[CTL_ILE] && !eff[CTL_WR1];
    load_dac = !eff[CTL_XFER] && !eff[CTL_WR2];
  end
endmodule

// File: rtl/dbf_stage.sv
module dbf_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/dbuf_dac_front.sv
module dbuf_dac_front
  import dbf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     din,
  input  logic             cs_n,
  input  logic             ile,
  input  logic             wr1_n,
  input  logic             wr2_n,
  input  logic             xfer_n,
  input  logic [CTL_N-1:0] ctl_float,
  output logic [W-1:0]     hold_q,
  output logic [W-1:0]     code_q,
  output logic [W:0]       span_q
);
  localparam logic [W:0] FULL = (W+1)'(1) << W;

  logic [CTL_N-1:0] raw;
  logic             load_in, load_dac;
  logic [W-1:0]     in_view;
  logic [W-1:0]     code_next;

  always_comb begin
    raw           = '0;
    raw[CTL_CS]   = cs_n;
    raw[CTL_ILE]  = ile;
    raw[CTL_WR1]  = wr1_n;
    raw[CTL_WR2]  = wr2_n;
    raw[CTL_XFER] = xfer_n;
  end

  dbf_ctl_resolve u_ctl (
    .raw      (raw),
    .flt      (ctl_float),
    .load_in  (load_in),
    .load_dac (load_dac)
  );

  dbf_stage #(.W(W)) u_in (
    .clk (clk), .rst (rst), .en (load_in), .d (din), .q (hold_q)
  );

  // same-edge pass-through when both stages open
  assign in_view   = load_in ? din : hold_q;
  assign code_next = load_dac ? in_view : code_q;

  dbf_stage #(.W(W)) u_dac (
    .clk (clk), .rst (rst), .en (load_dac), .d (in_view), .q (code_q)
  );

  always_ff @(posedge clk) begin
    if (rst) span_q <= FULL;
    else     span_q <= FULL - {1'b0, code_next};
  end
endmodule

// File: rtl/dbuf_dac_front_chk.sv
module dbuf_dac_front_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] din,
  input logic         cs_n,
  input logic         ile,
  input logic         wr1_n,
  input logic         wr2_n,
  input logic         xfer_n,
  input logic [4:0]   ctl_float,
  input logic [W-1:0] hold_q,
  input logic [W-1:0] code_q,
  input logic [W:0]   span_q
);
  logic open1, open2;
  assign open1 = !(cs_n | ctl_float[0]) && (ile | ctl_float[1]) && !(wr1_n | ctl_float[2]);
  assign open2 = !(wr2_n | ctl_float[3]) && !(xfer_n | ctl_float[4]);

  assert_stage1_load_R1: assert property (@(posedge clk) disable iff (rst)
    open1 |=> hold_q == $past(din));
  assert_stage1_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !open1 |=> $stable(hold_q));
  assert_stage2_copy_R3: assert property (@(posedge clk) disable iff (rst)
    (open2 && !open1) |=> code_q == $past(hold_q));
  assert_stage2_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !open2 |=> $stable(code_q));
  assert_flow_through_R4: assert property (@(posedge clk) disable iff (rst)
    (open1 && open2) |=> code_q == $past(din));
  assert_span_sum_R6: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, code_q} + span_q) == ((W+1)'(1) << W));
endmodule

bind dbuf_dac_front dbuf_dac_front_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .din(din), .cs_n(cs_n), .ile(ile), .wr1_n(wr1_n),
  .wr2_n(wr2_n), .xfer_n(xfer_n), .ctl_float(ctl_float),
  .hold_q(hold_q), .code_q(code_q), .span_q(span_q)
);

// File: tb/dbuf_dac_front_test.sv
module dbuf_dac_front_test;
  localparam int W = 8;
  localparam int FULL = 1 << W;

  logic clk = 0;
  always #2 clk = ~clk;

  logic         rst = 1;
  logic [W-1:0] din = '0;
  logic cs_a = 1, cs_b = 1, cs_c = 1;
  logic ile = 1, wr1_n = 1, wr2_n = 1, xfer_n = 1;
  logic [4:0] flt = '0;

  logic [W-1:0] hold_a, code_a, hold_b, code_b, hold_c, code_c;
  logic [W:0]   span_a, span_b, span_c;

  dbuf_dac_front #(.W(W)) uut (
    .clk(clk), .rst(rst), .din(din), .cs_n(cs_a), .ile(ile), .wr1_n(wr1_n),
    .wr2_n(wr2_n), .xfer_n(xfer_n), .ctl_float(flt),
    .hold_q(hold_a), .code_q(code_a), .span_q(span_a));
  dbuf_dac_front #(.W(W)) peer_b (
    .clk(clk), .rst(rst), .din(din), .cs_n(cs_b), .ile(ile), .wr1_n(wr1_n),
    .wr2_n(wr2_n), .xfer_n(xfer_n), .ctl_float(5'b0),
    .hold_q(hold_b), .code_q(code_b), .span_q(span_b));
  dbuf_dac_front #(.W(W)) peer_c (
    .clk(clk), .rst(rst), .din(din), .cs_n(cs_c), .ile(ile), .wr1_n(wr1_n),
    .wr2_n(wr2_n), .xfer_n(xfer_n), .ctl_float(5'b0),
    .hold_q(hold_c), .code_q(code_c), .span_q(span_c));

  int checks = 0, fails = 0;
  int eh = 0, ec = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // one edge; reference model of uut from the requirements
  task automatic step();
    bit c, l, w1, w2, x, o1, o2;
    int nh;
    c  = cs_a | flt[0];  l  = ile | flt[1];  w1 = wr1_n | flt[2];
    w2 = wr2_n | flt[3]; x  = xfer_n | flt[4];
    o1 = !c && l && !w1;
    o2 = !w2 && !x;
    @(posedge clk);
    #1;
    if (rst) begin eh = 0; ec = 0; end
    else begin
      nh = o1 ? int'(din) : eh;
      if (o2) ec = nh;
      eh = nh;
    end
  endtask

  task automatic idle();
    cs_a = 1; cs_b = 1; cs_c = 1; ile = 1; wr1_n = 1; wr2_n = 1; xfer_n = 1; flt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    step(); step();
    chk("R8 hold", hold_a, 0); chk("R8 code", code_a, 0); chk("R8 span", span_a, FULL);
    rst = 0;

    // R1/R2 all combinations of the staging enable
    for (int k = 0; k < 8; k++) begin
      idle();
      cs_a = k[0]; ile = k[1]; wr1_n = k[2]; din = W'(8'h10 + k);
      step();
      chk((k == 2) ? "R1 load" : "R2 hold", hold_a, eh);
      chk("R3 code idle", code_a, ec);
    end

    // R3 transfer combinations
    for (int k = 0; k < 4; k++) begin
      idle(); cs_a = 0; wr1_n = 0; din = W'(8'h40 + k);
      step();
      idle(); xfer_n = k[0]; wr2_n = k[1]; din = 8'hEE;
      step();
      chk("R3 transfer", code_a, (k == 0) ? 8'h40 : ec);
      chk("R3 model", code_a, ec);
      chk("R2 hold during xfer", hold_a, 8'h40 + k);
    end

    // R4/R6 flow-through sweep of every code
    idle(); cs_a = 0; wr1_n = 0; wr2_n = 0; xfer_n = 0;
    for (int d = 0; d < FULL; d++) begin
      din = W'(d);
      step();
      chk("R4 flow", code_a, d);
      chk("R6 span", span_a, FULL - d);
    end
    din = 8'h01; step();
    chk("R6 lsb bit0", code_a[0], 1); chk("R6 lsb span", span_a, FULL - 1);
    din = 8'hFF; step();
    chk("R6 full scale span", span_a, 1);

    // R5 level actuated: staging open, follows each value
    idle(); cs_a = 0; wr1_n = 0;
    for (int k = 0; k < 3; k++) begin
      din = W'(8'h21 * (k + 1));
      step();
      chk("R5 follow", hold_a, 8'h21 * (k + 1));
    end
    chk("R5 code held", code_a, 8'hFF);

    // R10 single-buffered: code stage held open
    idle(); wr2_n = 0; xfer_n = 0; cs_a = 0; wr1_n = 0; din = 8'h77;
    step(); chk("R10 write", code_a, 8'h77);
    cs_a = 1; din = 8'h99;
    step(); chk("R10 hold", code_a, 8'h77);
    cs_a = 0; din = 8'h12;
    step(); chk("R10 rewrite", code_a, 8'h12);

    // R7 undriven flags
    idle(); cs_a = 0; wr1_n = 0; flt = 5'b00001; din = 8'h5C;
    step(); chk("R7 cs float blocks", hold_a, 8'h12);
    idle(); cs_a = 0; wr1_n = 0; ile = 0; flt = 5'b00010; din = 8'h6D;
    step(); chk("R7 ile float enables", hold_a, 8'h6D);
    idle(); wr2_n = 0; xfer_n = 0; flt = 5'b10000;
    step(); chk("R7 xfer float blocks", code_a, 8'h12);
    idle(); wr2_n = 0; xfer_n = 0; flt = 5'b01000;
    step(); chk("R7 wr2 float blocks", code_a, 8'h12);

    // R9 shared transfer across three instances
    idle(); cs_a = 0; wr1_n = 0; din = 8'h3C; step();
    idle(); cs_b = 0; wr1_n = 0; din = 8'h5A; step();
    idle(); step();
    chk("R9 a before", code_a, 8'h12); chk("R9 b before", code_b, 0); chk("R9 c before", code_c, 0);
    idle(); wr2_n = 0; xfer_n = 0; step();
    chk("R9 a after", code_a, 8'h3C); chk("R9 b after", code_b, 8'h5A); chk("R9 c unchanged", code_c, 0);
    chk("R9 b span", span_b, FULL - 8'h5A);

    // R8 reset mid-run
    idle(); rst = 1; step(); rst = 0;
    chk("R8 reset hold", hold_a, 0); chk("R8 reset code", code_a, 0); chk("R8 reset span", span_a, FULL);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule